// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets a clocked request port drive an asynchronous 128K x 8 static RAM. A client offers one read or one write at a time, each with a 17-bit address and, for writes, a byte of data. The controller produces the memory's strobes: an active-low chip enable, an active-high chip select, an active-low write enable and an active-low output enable. It also produces the enable for the drivers on the shared data bus. When a request finishes, the controller raises a one-cycle completion pulse. For reads, the captured byte appears with that pulse.

Every timing rule of the memory is set as a nanosecond parameter. The rules are the access delays, the write-strobe width, the data and address setup, the cycle time and the output-float delay. They are turned into clock-cycle counts from the clock period. A single down-counter times each phase. The state machine has six states:
- IDLE: the memory is deselected and a request is accepted.
- WR_SETUP: the memory is selected, with the address placed and the strobes off.
- WR_STROBE: write enable is low and data is driven.
- WR_HOLD: write enable is back high, and data and selection are kept for one cycle.
- RD_ACCESS: the memory is selected with output enable low, held for the read access time.
- RECOVER: the memory is deselected and the bus is quiet.

The transitions are:
- accept-read: IDLE to RD_ACCESS.
- accept-write: IDLE to WR_SETUP.
- setup-done: WR_SETUP to WR_STROBE.
- strobe-done: WR_STROBE to WR_HOLD.
- hold-done: WR_HOLD to RECOVER.
- access-done: RD_ACCESS to RECOVER.
- recovered: RECOVER to IDLE.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset and whenever the controller is idle, the outputs are in the standby pattern: mem_ce_n=1, mem_cs=0, mem_we_n=1, mem_oe_n=1, mem_dq_oe=0 and req_ready=1.
- R2: A read keeps the memory selected, with mem_we_n=1 and mem_oe_n=0, for RD_CYC cycles. RD_CYC is the ceiling of the longest of the address, chip-enable and output-enable access delays and the cycle time, divided by the clock period: 18 at the defaults. The byte on mem_dq_in at the last of those cycles is returned on rsp_rdata.
- R3: rsp_done pulses for exactly one cycle per request. It is high RD_CYC+1 cycles after a read is accepted, and WE_CYC+3 cycles after a write is accepted.
- R4: During a write, mem_we_n is low for WE_CYC consecutive cycles. WE_CYC is the ceiling of the largest of the strobe width, the data setup and the address setup less one cycle: 15 at the defaults. req_wdata is driven throughout.
- R5: mem_dq_oe is high only during the write strobe and the one cycle after mem_we_n rises. It is never high while mem_oe_n is low.
- R6: mem_we_n is low only while the memory is selected and mem_oe_n is high.
- R7: mem_addr does not change while mem_ce_n is low.
- R8: After a read, the memory stays deselected with mem_oe_n high for REL_CYC cycles before the next request is accepted. REL_CYC is the output-float delay in cycles: 7 at the defaults. Once output enable has risen, the data drivers are not enabled again until that many cycles have passed.
- R9: After a write, the controller stays deselected long enough for the whole write to span at least the cycle time, and for at least one cycle. It returns to idle one cycle after rsp_done at the defaults.
- R10: A request is accepted only when req_ready is high. A req_valid raised while the controller is busy and dropped before it returns to idle has no effect on the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle; request accepted on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Captured read byte, valid with rsp_done |
| mem_addr | output | 17 | Memory address lines |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_cs | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the data bus drivers |
| mem_dq_in | input | 8 | Data read from the memory bus |

## Verification
A wrong state or a miscounted phase timer shows up at the memory pins within the same request. Sampling one cycle too early returns the memory's not-yet-valid byte on rsp_rdata. A short strobe is seen when mem_we_n rises. A skipped float guard shows up as a driver enable too soon after output enable rises. The bench's memory model returns a marker byte until the access delay has elapsed, and it rejects short strobes, unstable write data and bus contention. Wrong completion latency or recovery time is measured in cycles from acceptance. An accidental acceptance while busy corrupts a location that a later read then exposes.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_WR_SETUP  = 3'd1,
        ST_WR_STROBE = 3'd2,
        ST_WR_HOLD   = 3'd3,
        ST_RD_ACCESS = 3'd4,
        ST_RECOVER   = 3'd5
    } ctrl_state_e;

    function automatic int ns_to_cycles(input int ns, input int period_ps);
        return (ns * 1000 + period_ps - 1) / period_ps;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int TW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic          wr_finish,
    input  logic [DW-1:0] bus_in,
    output logic [DW-1:0] rdata,
    output logic          done
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
            done  <= 1'b0;
        end else begin
            done <= capture | wr_finish;
            if (capture)
                rdata <= bus_in;
        end
    end

    // R3: completion is a single-cycle pulse
    assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done held longer than one cycle");
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int AW       = 17,
    parameter int DW       = 8,
    parameter int CLK_PS   = 4000,
    parameter int ACC_NS   = 70,
    parameter int OE_NS    = 35,
    parameter int CYC_NS   = 70,
    parameter int WEP_NS   = 60,
    parameter int DSU_NS   = 30,
    parameter int ASU_NS   = 60,
    parameter int HIZ_NS   = 25
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_done,
    output logic [DW-1:0] rsp_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce_n,
    output logic          mem_cs,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in
);
    localparam int CYC_C   = ns_to_cycles(CYC_NS, CLK_PS);
    localparam int RD_CYC  = max_of(max_of(ns_to_cycles(ACC_NS, CLK_PS),
                                           ns_to_cycles(OE_NS, CLK_PS)), CYC_C);
    localparam int WE_CYC  = max_of(max_of(ns_to_cycles(WEP_NS, CLK_PS),
                                           ns_to_cycles(DSU_NS, CLK_PS)),
                                    max_of(ns_to_cycles(ASU_NS, CLK_PS) - 1, 1));
    localparam int REL_CYC = max_of(ns_to_cycles(HIZ_NS, CLK_PS), 1);
    localparam int WR_USED = WE_CYC + 2;
    localparam int WR_REC  = max_of(CYC_C - WR_USED, 1);
    localparam int TW      = $clog2(RD_CYC + WE_CYC + REL_CYC + WR_REC + 2);

    ctrl_state_e   state_q, state_d;
    logic          tmr_load, tmr_expired;
    logic [TW-1:0] tmr_val;
    logic          cap_rd, wr_finish;
    logic [DW-1:0] wdata_q;
    logic          accept;

    assign accept = (state_q == ST_IDLE) && req_valid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // request latch: address only moves on acceptance, while deselected
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_addr <= '0;
            wdata_q  <= '0;
        end else if (accept) begin
            mem_addr <= req_addr;
            wdata_q  <= req_wdata;
        end
    end

    // next state and phase timer loading
    always_comb begin
        state_d   = state_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        cap_rd    = 1'b0;
        wr_finish = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    tmr_load = 1'b1;
                    if (req_write) begin
                        state_d = ST_WR_SETUP;
                    end else begin
                        state_d = ST_RD_ACCESS;
                        tmr_val = TW'(RD_CYC - 1);
                    end
                end
            end
            ST_WR_SETUP: begin
                if (tmr_expired) begin
                    state_d  = ST_WR_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(WE_CYC - 1);
                end
            end
            ST_WR_STROBE: begin
                if (tmr_expired) begin
                    state_d  = ST_WR_HOLD;
                    tmr_load = 1'b1;
                end
            end
            ST_WR_HOLD: begin
                state_d   = ST_RECOVER;
                tmr_load  = 1'b1;
                tmr_val   = TW'(WR_REC - 1);
                wr_finish = 1'b1;
            end
            ST_RD_ACCESS: begin
                if (tmr_expired) begin
                    state_d  = ST_RECOVER;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(REL_CYC - 1);
                    cap_rd   = 1'b1;
                end
            end
            ST_RECOVER: begin
                if (tmr_expired)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from the registered state
    always_comb begin
        req_ready  = 1'b0;
        mem_ce_n   = 1'b1;
        mem_cs     = 1'b0;
        mem_we_n   = 1'b1;
        mem_oe_n   = 1'b1;
        mem_dq_oe  = 1'b0;
        unique case (state_q)
            ST_IDLE:      req_ready = 1'b1;
            ST_WR_SETUP: begin
                mem_ce_n = 1'b0;
                mem_cs   = 1'b1;
            end
            ST_WR_STROBE: begin
                mem_ce_n  = 1'b0;
                mem_cs    = 1'b1;
                mem_we_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            ST_WR_HOLD: begin
                mem_ce_n  = 1'b0;
                mem_cs    = 1'b1;
                mem_dq_oe = 1'b1;
            end
            ST_RD_ACCESS: begin
                mem_ce_n = 1'b0;
                mem_cs   = 1'b1;
                mem_oe_n = 1'b0;
            end
            ST_RECOVER: ;
            default: ;
        endcase
    end

    assign mem_dq_out = wdata_q;

    sram_phase_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_rd_capture #(.DW(DW)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (cap_rd),
        .wr_finish (wr_finish),
        .bus_in    (mem_dq_in),
        .rdata     (rsp_rdata),
        .done      (rsp_done)
    );

    // ---------------- checks on the memory-side timing ----------------
    localparam int GW = $clog2(WE_CYC + REL_CYC + 2);
    logic [GW-1:0] we_low_cnt, oe_high_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_low_cnt  <= '0;
            oe_high_cnt <= GW'(REL_CYC);
        end else begin
            we_low_cnt <= mem_we_n ? '0 : we_low_cnt + 1'b1;
            if (!mem_oe_n)
                oe_high_cnt <= '0;
            else if (oe_high_cnt < GW'(REL_CYC))
                oe_high_cnt <= oe_high_cnt + 1'b1;
        end
    end

    assert_idle_standby_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe))
        else $error("idle outputs not in standby pattern");

    assert_strobe_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_low_cnt >= GW'(WE_CYC)))
        else $error("write strobe shorter than required");

    assert_no_contention_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n)
        else $error("drivers on while memory output enabled");

    assert_we_guarded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_cs && mem_oe_n))
        else $error("write strobe outside a selected, output-disabled window");

    assert_addr_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !accept) |=> $stable(mem_addr))
        else $error("address moved while chip enabled");

    assert_float_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (oe_high_cnt >= GW'(REL_CYC)))
        else $error("drivers enabled before memory output floated");

    assert_accept_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(mem_addr) || (state_q == ST_IDLE))
        else $error("request latched while busy");
endmodule

// File: tb/sram_async_ctrl_test.sv
module sram_async_ctrl_test;
    localparam int RD_CYC  = 18;
    localparam int WE_CYC  = 15;
    localparam int REL_CYC = 7;
    localparam int WR_REC  = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_done;
    logic [7:0]  rsp_rdata;
    logic [16:0] mem_addr;
    logic        mem_ce_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'h00;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    sram_async_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_cs(mem_cs), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural memory model ----------------
    logic [7:0] model_mem [logic [16:0]];
    logic [7:0] shadow    [logic [16:0]];
    int         rd_cnt = 0, we_cnt = 0, dq_stab = 0;
    logic       prev_wr = 1'b0;
    logic [16:0] prev_addr = '0;
    logic [7:0]  prev_dq = '0;
    logic        prev_dq_oe = 1'b0;

    function automatic logic [7:0] expect_byte(input logic [16:0] a);
        return shadow.exists(a) ? shadow[a] : 8'h00;
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            logic sel;
            sel = !mem_ce_n && mem_cs;
            if (mem_dq_oe && !mem_oe_n)
                check(1'b0, "R5 contention", 1, 0);
            // write detection: strobe end
            if (prev_wr && !(sel && !mem_we_n)) begin
                check(we_cnt >= WE_CYC, "R4 strobe width", we_cnt, WE_CYC);
                check(dq_stab >= 8, "R4 data setup", dq_stab, 8);
                model_mem[prev_addr] = prev_dq;
            end
            we_cnt  = (sel && !mem_we_n) ? we_cnt + 1 : 0;
            dq_stab = (mem_dq_oe && prev_dq_oe && mem_dq_out == prev_dq) ? dq_stab + 1
                    : (mem_dq_oe ? 1 : 0);
            prev_wr    = sel && !mem_we_n;
            prev_dq    = mem_dq_out;
            prev_dq_oe = mem_dq_oe;
            // read path with access delay
            if (sel && !mem_oe_n && mem_we_n)
                rd_cnt = (rd_cnt == 0 || mem_addr == prev_addr) ? rd_cnt + 1 : 1;
            else
                rd_cnt = 0;
            prev_addr = mem_addr;
            if (rd_cnt >= RD_CYC)
                mem_dq_in <= model_mem.exists(mem_addr) ? model_mem[mem_addr] : 8'h00;
            else if (rd_cnt > 0)
                mem_dq_in <= 8'hEE;
            else
                mem_dq_in <= 8'h00;
        end
    end

    // ---------------- request tasks ----------------
    task automatic run_req(input bit wr, input logic [16:0] a, input logic [7:0] d,
                           output int lat, output int rec, output logic [7:0] q);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        q = rsp_rdata;
        @(negedge clk);
        check(!rsp_done, "R3 done single", rsp_done, 0);
        rec = 1;
        while (!req_ready && rec < 200) begin
            check(mem_ce_n && mem_oe_n, "R8 deselected in recovery", mem_ce_n, 1);
            @(negedge clk);
            rec++;
        end
    endtask

    task automatic do_write(input logic [16:0] a, input logic [7:0] d);
        int lat, rec;
        logic [7:0] q;
        run_req(1'b1, a, d, lat, rec, q);
        shadow[a] = d;
        check(lat == WE_CYC + 3, "R3 write latency", lat, WE_CYC + 3);
        check(rec == WR_REC, "R9 write recovery", rec, WR_REC);
    endtask

    task automatic do_read(input logic [16:0] a);
        int lat, rec;
        logic [7:0] q;
        run_req(1'b0, a, 8'h00, lat, rec, q);
        check(q == expect_byte(a), "R2 read data", q, expect_byte(a));
        check(lat == RD_CYC + 1, "R3 read latency", lat, RD_CYC + 1);
        check(rec == REL_CYC, "R8 read release", rec, REL_CYC);
    endtask

    // watchdog
    initial begin
        #(4 * 150000);
        check(1'b0, "watchdog", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(req_ready && mem_ce_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_done,
              "R1 reset state", {req_ready, mem_ce_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe}, 6'b110110);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && mem_ce_n && !mem_cs, "R1 idle standby", mem_ce_n, 1);

        // directed corners
        do_read(17'h00123);                // unwritten location
        do_write(17'h00000, 8'hA5);
        do_write(17'h1FFFF, 8'h5A);
        do_read(17'h00000);
        do_read(17'h1FFFF);
        do_write(17'h00042, 8'h3C);
        do_read(17'h00042);                // write then read same address

        // R10: valid pulsed while busy must not start a request
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 17'h00042;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00042; req_wdata = 8'hFF;
        repeat (3) @(negedge clk);
        check(!req_ready, "R10 ready low while busy", req_ready, 0);
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
        check(mem_ce_n && mem_we_n, "R1 idle after busy pulse", mem_ce_n, 1);
        do_read(17'h00042);                // still 8'h3C

        // random mix
        for (int i = 0; i < 250; i++) begin
            logic [16:0] a;
            logic [7:0]  d;
            a = ($urandom % 4 == 0) ? 17'($urandom % 16) : 17'($urandom);
            d = 8'($urandom);
            if ($urandom % 2) do_write(a, d);
            else              do_read(a);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule